// File: doc/BRIEF.md
# Host Data Handshake Port

This block joins an 8-bit host bus to a 24-bit word interface on the processor side. The host sees a control register, a command vector register, a read-only status register, an interrupt vector register and one byte-wide window per lane of the data word. The processor sees a small status vector and separate read and write strobes for whole words.

Data moves in each direction through two stages, and each stage has its own full or empty flag. A word written by the host waits in a byte holding stage until the processor's receive word is free. A word written by the processor waits until the host has drained its read bytes. When the processor side is idle, a host write of the low byte can go straight into the processor's receive word. The host request output is formed by masking the host status flags with enable bits in the control register. The command vector register signals a pending host command to the processor.

The host accesses one register per cycle. The strobes are single-cycle and the read data is combinational. Every flag update takes effect at the clock edge that samples the strobe.

Top module: `host_xfer_port`

## Requirements
- R1: After reset, control reads 0x00, command vector reads 0x12, interrupt vector reads 0x0F and host status reads 0x06. In host status, bit 1 is transmit-empty, bit 2 is transmit-ready and bit 0 is receive-full. The processor status vector is 5'b00010: bit 1 is transmit-empty, bit 0 is receive-full, bit 2 is command pending, and bits 3 and 4 are the host flags.
- R2: Host status bit 2 (transmit-ready) always equals host transmit-empty AND NOT processor receive-full.
- R3: A low-byte host write (address 7) made while transmit-ready is 0 clears transmit-empty. Whenever host transmit-empty is 0 and processor receive-full is 0, the held bytes move into the processor word in the same cycle. That transfer sets both flags. Address 5 holds the high byte and address 6 the middle byte.
- R4: A low-byte host write made while transmit-ready is 1 loads the processor word directly and sets processor receive-full. Host transmit-empty stays 1.
- R5: A processor write clears processor transmit-empty. Whenever host receive-full is 0 and processor transmit-empty is 0, the word is split into the host bytes at addresses 5 (high), 6 and 7 (low). That transfer sets both flags.
- R6: A host read of address 7 clears host receive-full, and a processor read clears processor receive-full. A pending transfer in the freed direction then completes at the same clock edge.
- R7: Host status bit 7 and `host_irq` are 1 exactly when (control[1:0] AND status[1:0]) is nonzero.
- R8: Control writes are masked with 0xFB. Control bits 3 and 4 appear as processor status bits 3 and 4.
- R9: Host status bit 6 is 1 whenever control bits [6:5] are nonzero.
- R10: A control write with bit 7 set acts on bits 0 and 1. Bit 0 clears host receive-full and sets processor transmit-empty. Bit 1 sets host transmit-empty and clears processor receive-full. Bit 7 then reads back as 0.
- R11: Command vector writes are masked with 0x9F. Its bit 7 drives processor status bit 2 and `p_cmd_irq`. Bits [4:0] appear on `p_cmd_vec`.
- R12: Host writes to address 2 (status) and address 4 (unused) change no register. Address 4 reads 0.
- R13: `p_rx_irq` follows processor receive-full and `p_tx_irq` follows processor transmit-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects at address 7) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| host_irq | output | 1 | Host request |
| p_wr | input | 1 | Processor word write strobe |
| p_wdata | input | 24 | Processor word to send to the host |
| p_rd | input | 1 | Processor word read strobe |
| p_rdata | output | 24 | Word received from the host |
| p_status | output | 5 | Processor status vector |
| p_cmd_vec | output | 5 | Host command vector |
| p_cmd_irq | output | 1 | Host command pending |
| p_rx_irq | output | 1 | Received word available |
| p_tx_irq | output | 1 | Transmit word empty |

## Verification
A flag left in the wrong state shows at the ports in the next cycle. The status register, the processor status vector and the three interrupt outputs all decode the four handshake flags directly. A missed or doubled transfer therefore shows as a stale `p_rdata` or a stale host byte at the next check. Every host or processor access is followed by a full comparison of all readable state against a bench model. Divergence is reported within one access of its cause.

// File: rtl/hxp_pkg.sv
package hxp_pkg;
  localparam int HADDR_W = 3;
  localparam int HBYTE_W = 8;

  localparam logic [HADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [HADDR_W-1:0] A_VEC  = 3'd1;
  localparam logic [HADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [HADDR_W-1:0] A_IVEC = 3'd3;

  localparam int CTL_RXREQ = 0;
  localparam int CTL_TXREQ = 1;
  localparam int CTL_FLAG0 = 3;
  localparam int CTL_FLAG1 = 4;
  localparam int CTL_MODE0 = 5;
  localparam int CTL_MODE1 = 6;
  localparam int CTL_INIT  = 7;

  localparam logic [HBYTE_W-1:0] CTL_WMASK = 8'hFB;
  localparam logic [HBYTE_W-1:0] VEC_WMASK = 8'h9F;
  localparam logic [HBYTE_W-1:0] VEC_RST   = 8'h12;
  localparam logic [HBYTE_W-1:0] IVEC_RST  = 8'h0F;

  localparam int VEC_CMD = 7;
endpackage

// File: rtl/hxp_ctrl_regs.sv
module hxp_ctrl_regs
  import hxp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_vec,
  input  logic               wr_ivec,
  input  logic [HBYTE_W-1:0] wdata,
  output logic [HBYTE_W-1:0] ctrl_q,
  output logic [HBYTE_W-1:0] vec_q,
  output logic [HBYTE_W-1:0] ivec_q,
  output logic               init_rx,
  output logic               init_tx
);
  logic [HBYTE_W-1:0] ctrl_d, vec_d, ivec_d, masked;

  always_comb begin
    masked  = wdata & CTL_WMASK;
    ctrl_d  = ctrl_q;
    init_rx = 1'b0;
    init_tx = 1'b0;
    if (wr_ctrl) begin
      ctrl_d           = masked;
      ctrl_d[CTL_INIT] = 1'b0;
      init_rx          = masked[CTL_INIT] & masked[CTL_RXREQ];
      init_tx          = masked[CTL_INIT] & masked[CTL_TXREQ];
    end
    vec_d  = wr_vec  ? (wdata & VEC_WMASK) : vec_q;
    ivec_d = wr_ivec ? wdata : ivec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      vec_q  <= VEC_RST;
      ivec_q <= IVEC_RST;
    end else begin
      ctrl_q <= ctrl_d;
      vec_q  <= vec_d;
      ivec_q <= ivec_d;
    end
  end

  // R11: a pending command only appears after a host vector write with bit 7
  p_cmd_from_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_q[VEC_CMD]) |-> $past(wr_vec && wdata[VEC_CMD]));

  // R10: the init bit never survives into the stored control value
  p_init_selfclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !ctrl_q[CTL_INIT]);
endmodule

// File: rtl/hxp_h2p.sv
module hxp_h2p
  import hxp_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int WORD_W = NBYTES * HBYTE_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBYTES-1:0]  lane_wr,
  input  logic [HBYTE_W-1:0] wdata,
  input  logic               p_rd,
  input  logic               init_tx,
  output logic               txde,
  output logic               hrdf,
  output logic [WORD_W-1:0]  rx_word
);
  logic [WORD_W-1:0] hold_q, hold_d, rx_d;
  logic txde_s, hrdf_s, txde_d, hrdf_d;

  always_comb begin
    hold_d = hold_q;
    for (int k = 0; k < NBYTES; k++)
      if (lane_wr[k]) hold_d[k*HBYTE_W +: HBYTE_W] = wdata;
    rx_d   = rx_word;
    txde_s = txde;
    hrdf_s = hrdf;
    if (p_rd) hrdf_s = 1'b0;
    if (lane_wr[0]) begin
      if (txde && !hrdf) begin
        rx_d   = hold_d;
        hrdf_s = 1'b1;
      end else begin
        txde_s = 1'b0;
      end
    end
    if (init_tx) begin
      txde_s = 1'b1;
      hrdf_s = 1'b0;
    end
    txde_d = txde_s;
    hrdf_d = hrdf_s;
    if (!txde_s && !hrdf_s) begin
      rx_d   = hold_d;
      txde_d = 1'b1;
      hrdf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rx_word <= '0;
      txde    <= 1'b1;
      hrdf    <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      rx_word <= rx_d;
      txde    <= txde_d;
      hrdf    <= hrdf_d;
    end
  end

  // R3/R4: whenever the processor word fills, the host stage is empty
  p_fill_leaves_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrdf) |-> txde);

  // R3: only a low-byte host write can empty-clear the host stage
  p_txde_fall_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txde) |-> $past(lane_wr[0]));
endmodule

// File: rtl/hxp_p2h.sv
module hxp_p2h
  import hxp_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int WORD_W = NBYTES * HBYTE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_wr,
  input  logic [WORD_W-1:0] p_wdata,
  input  logic              lo_rd,
  input  logic              init_rx,
  output logic              rxdf,
  output logic              htde,
  output logic [WORD_W-1:0] host_bytes
);
  logic [WORD_W-1:0] src_q, src_d, hb_d;
  logic rxdf_s, htde_s, rxdf_d, htde_d;

  always_comb begin
    src_d  = p_wr ? p_wdata : src_q;
    hb_d   = host_bytes;
    rxdf_s = rxdf;
    htde_s = htde;
    if (lo_rd) rxdf_s = 1'b0;
    if (p_wr)  htde_s = 1'b0;
    if (init_rx) begin
      rxdf_s = 1'b0;
      htde_s = 1'b1;
    end
    rxdf_d = rxdf_s;
    htde_d = htde_s;
    if (!rxdf_s && !htde_s) begin
      hb_d   = src_d;
      rxdf_d = 1'b1;
      htde_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= '0;
      host_bytes <= '0;
      rxdf       <= 1'b0;
      htde       <= 1'b1;
    end else begin
      src_q      <= src_d;
      host_bytes <= hb_d;
      rxdf       <= rxdf_d;
      htde       <= htde_d;
    end
  end

  // R5: host bytes only fill together with the processor stage emptying
  p_fill_leaves_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxdf) |-> htde);

  // R5: processor stage only leaves empty after a processor write
  p_htde_fall_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(htde) |-> $past(p_wr));
endmodule

// File: rtl/host_xfer_port.sv
module host_xfer_port
  import hxp_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int WORD_W = NBYTES * HBYTE_W,
  localparam int DATA_BASE = (1 << HADDR_W) - NBYTES
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [HBYTE_W-1:0] h_wdata,
  output logic [HBYTE_W-1:0] h_rdata,
  output logic               host_irq,
  input  logic               p_wr,
  input  logic [WORD_W-1:0]  p_wdata,
  input  logic               p_rd,
  output logic [WORD_W-1:0]  p_rdata,
  output logic [4:0]         p_status,
  output logic [4:0]         p_cmd_vec,
  output logic               p_cmd_irq,
  output logic               p_rx_irq,
  output logic               p_tx_irq
);
  logic [HBYTE_W-1:0] ctrl_q, vec_q, ivec_q, isr;
  logic [NBYTES-1:0]  lane_wr;
  logic [WORD_W-1:0]  host_bytes;
  logic init_rx, init_tx, txde, hrdf, rxdf, htde, lo_rd, hreq, dma_on;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lane_wr[k] = h_wr && (h_addr == HADDR_W'(DATA_BASE + NBYTES - 1 - k));
  end

  assign lo_rd = h_rd && (h_addr == HADDR_W'(DATA_BASE + NBYTES - 1));

  hxp_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (h_wr && h_addr == A_CTRL),
    .wr_vec  (h_wr && h_addr == A_VEC),
    .wr_ivec (h_wr && h_addr == A_IVEC),
    .wdata   (h_wdata),
    .ctrl_q  (ctrl_q),
    .vec_q   (vec_q),
    .ivec_q  (ivec_q),
    .init_rx (init_rx),
    .init_tx (init_tx)
  );

  hxp_h2p #(.NBYTES(NBYTES)) u_h2p (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_wr (lane_wr),
    .wdata   (h_wdata),
    .p_rd    (p_rd),
    .init_tx (init_tx),
    .txde    (txde),
    .hrdf    (hrdf),
    .rx_word (p_rdata)
  );

  hxp_p2h #(.NBYTES(NBYTES)) u_p2h (
    .clk        (clk),
    .rst_n      (rst_n),
    .p_wr       (p_wr),
    .p_wdata    (p_wdata),
    .lo_rd      (lo_rd),
    .init_rx    (init_rx),
    .rxdf       (rxdf),
    .htde       (htde),
    .host_bytes (host_bytes)
  );

  always_comb begin
    hreq   = |(ctrl_q[CTL_TXREQ:CTL_RXREQ] & {txde, rxdf});
    dma_on = ctrl_q[CTL_MODE0] | ctrl_q[CTL_MODE1];
    isr    = {hreq, dma_on, 3'b000, txde & ~hrdf, txde, rxdf};
  end

  always_comb begin
    h_rdata = '0;
    case (h_addr)
      A_CTRL:  h_rdata = ctrl_q;
      A_VEC:   h_rdata = vec_q;
      A_STAT:  h_rdata = isr;
      A_IVEC:  h_rdata = ivec_q;
      default: begin
        for (int k = 0; k < NBYTES; k++)
          if (h_addr == HADDR_W'(DATA_BASE + NBYTES - 1 - k))
            h_rdata = host_bytes[k*HBYTE_W +: HBYTE_W];
      end
    endcase
  end

  assign host_irq  = hreq;
  assign p_status  = {ctrl_q[CTL_FLAG1], ctrl_q[CTL_FLAG0], vec_q[VEC_CMD], htde, hrdf};
  assign p_cmd_vec = vec_q[4:0];
  assign p_cmd_irq = vec_q[VEC_CMD];
  assign p_rx_irq  = hrdf;
  assign p_tx_irq  = htde;

  // R12: a status-address write alone leaves the host status unchanged
  p_stat_wr_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == A_STAT && !p_wr && !p_rd) |=> $stable(isr));

  // R7: a host request needs at least one enable bit
  p_hreq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (ctrl_q[CTL_RXREQ] || ctrl_q[CTL_TXREQ]));
endmodule

// File: tb/tb_host_xfer_port.sv
`timescale 1ns/1ps
module tb_host_xfer_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        host_irq;
  logic        p_wr = 1'b0, p_rd = 1'b0;
  logic [23:0] p_wdata = '0;
  logic [23:0] p_rdata;
  logic [4:0]  p_status, p_cmd_vec;
  logic        p_cmd_irq, p_rx_irq, p_tx_irq;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0]  m_ctl, m_vec, m_ivec;
  logic [23:0] m_hold, m_rxw, m_src, m_hb;
  logic        m_txde, m_hrdf, m_rxdf, m_htde;

  always #2.5 clk = ~clk;

  host_xfer_port dut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
    .p_wr(p_wr), .p_wdata(p_wdata), .p_rd(p_rd), .p_rdata(p_rdata),
    .p_status(p_status), .p_cmd_vec(p_cmd_vec), .p_cmd_irq(p_cmd_irq),
    .p_rx_irq(p_rx_irq), .p_tx_irq(p_tx_irq)
  );

  function automatic logic [7:0] exp_isr();
    logic hr;
    hr = (m_ctl[0] & m_rxdf) | (m_ctl[1] & m_txde);
    return {hr, m_ctl[6] | m_ctl[5], 3'b000, m_txde & ~m_hrdf, m_txde, m_rxdf};
  endfunction

  function automatic logic [4:0] exp_pstat();
    return {m_ctl[4], m_ctl[3], m_vec[7], m_htde, m_hrdf};
  endfunction

  task automatic m_transfer();
    if (!m_txde && !m_hrdf) begin m_rxw = m_hold; m_txde = 1; m_hrdf = 1; end
    if (!m_rxdf && !m_htde) begin m_hb = m_src; m_htde = 1; m_rxdf = 1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    h_addr = a;
    #1 v = h_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    peek(3'd0, v); chk({tag, " R8/R10 ctrl"}, v, m_ctl);
    peek(3'd1, v); chk({tag, " R11 vec"}, v, m_vec);
    peek(3'd2, v); chk({tag, " R2/R7/R9 status"}, v, exp_isr());
    peek(3'd3, v); chk({tag, " R12 ivec"}, v, m_ivec);
    peek(3'd4, v); chk({tag, " R12 unused"}, v, 8'h00);
    peek(3'd5, v); chk({tag, " R5 byte hi"}, v, m_hb[23:16]);
    peek(3'd6, v); chk({tag, " R5 byte mid"}, v, m_hb[15:8]);
    peek(3'd7, v); chk({tag, " R5 byte lo"}, v, m_hb[7:0]);
    chk({tag, " R3/R4 p_rdata"}, p_rdata, m_rxw);
    chk({tag, " R8/R11 p_status"}, p_status, exp_pstat());
    chk({tag, " R7 host_irq"}, host_irq, exp_isr() >> 7);
    chk({tag, " R11 cmd"}, {p_cmd_irq, p_cmd_vec}, {m_vec[7], m_vec[4:0]});
    chk({tag, " R13 irqs"}, {p_rx_irq, p_tx_irq}, {m_hrdf, m_htde});
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d, input string tag);
    logic [7:0] c;
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wr = 1;
    @(negedge clk);
    h_wr = 0;
    case (a)
      3'd0: begin
        c = d & 8'hFB;
        if (c[7]) begin
          if (c[0]) begin m_rxdf = 0; m_htde = 1; end
          if (c[1]) begin m_txde = 1; m_hrdf = 0; end
        end
        c[7] = 0;
        m_ctl = c;
      end
      3'd1: m_vec = d & 8'h9F;
      3'd3: m_ivec = d;
      3'd5: m_hold[23:16] = d;
      3'd6: m_hold[15:8] = d;
      3'd7: begin
        m_hold[7:0] = d;
        if (m_txde && !m_hrdf) begin m_rxw = m_hold; m_hrdf = 1; end
        else m_txde = 0;
      end
      default: ;
    endcase
    m_transfer();
    check_all(tag);
  endtask

  task automatic host_read_lo(input string tag);
    logic [7:0] v;
    @(negedge clk);
    h_addr = 3'd7; h_rd = 1;
    #1 v = h_rdata;
    chk({tag, " R6 low read data"}, v, m_hb[7:0]);
    @(negedge clk);
    h_rd = 0;
    m_rxdf = 0;
    m_transfer();
    check_all(tag);
  endtask

  task automatic proc_write(input logic [23:0] w, input string tag);
    @(negedge clk);
    p_wdata = w; p_wr = 1;
    @(negedge clk);
    p_wr = 0;
    m_src = w; m_htde = 0;
    m_transfer();
    check_all(tag);
  endtask

  task automatic proc_read(input string tag);
    logic [23:0] v;
    @(negedge clk);
    p_rd = 1;
    #1 v = p_rdata;
    chk({tag, " R6 proc read data"}, v, m_rxw);
    @(negedge clk);
    p_rd = 0;
    m_hrdf = 0;
    m_transfer();
    check_all(tag);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7411));
    m_ctl = 8'h00; m_vec = 8'h12; m_ivec = 8'h0F;
    m_hold = '0; m_rxw = '0; m_src = '0; m_hb = '0;
    m_txde = 1; m_hrdf = 0; m_rxdf = 0; m_htde = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    check_all("R1");
    peek(3'd2, v); chk("R1 status literal", v, 8'h06);
    chk("R1 p_status literal", p_status, 5'b00010);

    // R4 burst: processor side idle
    host_write(3'd5, 8'hAA, "R4");
    host_write(3'd6, 8'hBB, "R4");
    host_write(3'd7, 8'hCC, "R4");
    chk("R4 burst word", p_rdata, 24'hAABBCC);
    peek(3'd2, v); chk("R4 txde kept, trdy low", v[2:1], 2'b01);

    // R3 buffered path
    host_write(3'd5, 8'h11, "R3");
    host_write(3'd6, 8'h22, "R3");
    host_write(3'd7, 8'h33, "R3");
    peek(3'd2, v); chk("R3 txde cleared", v[1], 1'b0);
    proc_read("R6");
    chk("R3 queued word delivered", p_rdata, 24'h112233);
    peek(3'd2, v); chk("R3 txde set again", v[1], 1'b1);

    // R5/R7 processor to host, request enabled on receive-full
    host_write(3'd0, 8'h01, "R7");
    proc_write(24'h445566, "R5");
    chk("R7 host_irq on rxdf", host_irq, 1'b1);
    proc_write(24'h778899, "R5");
    chk("R13 tx irq low while queued", p_tx_irq, 1'b0);
    host_read_lo("R6");
    peek(3'd5, v); chk("R6 retried transfer", v, 8'h77);
    chk("R13 tx irq back", p_tx_irq, 1'b1);

    // R8 / R9 / R10
    host_write(3'd0, 8'h04, "R8");
    peek(3'd0, v); chk("R8 bit2 masked", v, 8'h00);
    host_write(3'd0, 8'h18, "R8");
    chk("R8 host flags", p_status[4:3], 2'b11);
    host_write(3'd0, 8'h40, "R9");
    peek(3'd2, v); chk("R9 dma bit", v[6], 1'b1);
    proc_write(24'h0A0B0C, "R10");
    host_write(3'd5, 8'h01, "R10");
    host_write(3'd7, 8'h02, "R10");
    host_write(3'd0, 8'h83, "R10");
    peek(3'd0, v); chk("R10 init self-clears", v, 8'h03);
    peek(3'd2, v); chk("R10 flags after init", v[1:0], 2'b10);

    // R11 / R12
    host_write(3'd1, 8'hFF, "R11");
    peek(3'd1, v); chk("R11 mask", v, 8'h9F);
    chk("R11 cmd irq", p_cmd_irq, 1'b1);
    host_write(3'd1, 8'h05, "R11");
    chk("R11 cmd cleared", p_cmd_irq, 1'b0);
    host_write(3'd2, 8'hFF, "R12");
    host_write(3'd4, 8'h5A, "R12");

    // constrained random traffic
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: host_write(3'($urandom % 8), 8'($urandom), "RND");
        1, 2: host_write(3'(5 + $urandom % 3), 8'($urandom), "RND");
        3: host_read_lo("RND");
        4, 5: proc_write(24'($urandom), "RND");
        default: proc_read("RND");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule